// File: doc/BRIEF.md
# Runtime Loop Capture Buffer

The block is a small tagless instruction store that sits beside the level-one instruction cache. It watches the fetch stream for a taken short backward branch. When one arrives, it treats the span from the branch target up to the branch as a loop. On the next pass through that span it writes every fetched instruction into its own entries, in order. On later passes it supplies those instructions itself, and the processor takes them instead of the L1 output.

The store has no tags. It serves a fetch only after it holds every instruction of the loop, so it never misses while it serves. Filling must be strictly sequential. A taken branch inside the loop, other than the closing one, or a jump in the fetch address, aborts the capture. As a result, a loop with an internal if/else can cycle between idle and filling without ever serving a fetch. This is accepted behaviour.

The controller has four states: idle, fill, active and abort. The store entry for a fetch is the fetch address minus the loop start address. The loop length comes from the branch offset.

Top module: `loop_capture_buf`

## Requirements
- R1: After a synchronous active-low reset, and at any later reset, the block is idle. `use_store` is 0 and `insn_out` equals `l1_insn` until a new loop has been captured completely.
- R2: In idle, `sbb_taken` at address P with offset K, where K < DEPTH, arms capture of the loop from P-K to P, with K+1 entries. If K >= DEPTH, nothing is captured and the store is never selected for that loop.
- R3: During the capture pass, `use_store` is 0 and `insn_out` equals `l1_insn`.
- R4: The capture pass completes when the loop-end address arrives with `sbb_taken` = 1 and no abort has happened. On every following pass, each loop address gives `use_store` = 1 and `insn_out` equal to the word written during capture, whatever `l1_insn` carries.
- R5: During capture, `cof_taken` = 1 at any loop address, or `sbb_taken` = 1 at an address other than the loop end, moves the block to a one-cycle abort state and then to idle. In the abort cycle, `sbb_taken` is ignored. After an abort, the loop is not served.
- R6: During capture, a fetch address different from the next sequential loop address aborts the capture, as in R5.
- R7: In active, reaching the loop end with `sbb_taken` = 0 still serves that end word from the store. The next fetch comes from L1, and the block is idle.
- R8: In active, `cof_taken` = 1 serves the current word from the store. Fetching returns to L1 from the next cycle, and the block is idle.
- R9: In active, a fetch address outside the captured range selects L1 in that same cycle, and the block is idle from the next cycle.
- R10: A loop of exactly DEPTH instructions (K = DEPTH-1) is captured and served in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | AW | Instruction address fetched this cycle |
| l1_insn | input | IW | Instruction word delivered by L1 for `fetch_pc` |
| sbb_taken | input | 1 | The instruction at `fetch_pc` is a taken short backward branch |
| cof_taken | input | 1 | The instruction at `fetch_pc` is some other taken control-flow change |
| sbb_off | input | OFFW | Backward distance of the branch, counted in instructions |
| insn_out | output | IW | Instruction given to the processor |
| use_store | output | 1 | 1 when `insn_out` comes from the loop store, 0 when it comes from L1 |

## Verification
Two events can fall in the same cycle: the last write of a capture pass and the decision that ends it. This happens when the instruction at the loop end is written while its branch flags choose between going active and leaving. The bench provokes this by raising `cof_taken` instead of `sbb_taken` exactly at the loop end of a capture pass. It then expects the following passes to come from L1. It also closes a capture normally and expects the very next pass to come entirely from the store with the words of the capture pass. A second case is the exit from active on a mid-loop `cof_taken`. There the current word must still come from the store while the next fetch already comes from L1.

// File: rtl/lcb_pkg.sv
// Package: shared types for the loop capture buffer.
// Assumes: nothing beyond standard SystemVerilog.
package lcb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_ABORT  = 2'd3
    } lcb_state_e;
endpackage

// File: rtl/lcb_xlate.sv
// Module: lcb_xlate
// Turns a fetch address into a store index relative to the loop base,
// and flags whether the address lies within [base, base+span].
// Assumes: DEPTH is a power of two, span < DEPTH.
module lcb_xlate #(
    parameter int AW    = 16,
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic [AW-1:0]   pc,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   span,
    output logic [AW-1:0]   diff,
    output logic [IDXW-1:0] idx,
    output logic            in_range
);
    // Offset from the loop base; the unsigned compare also rejects addresses below base.
    always_comb begin
        diff     = pc - base;
        in_range = (diff <= span);
        idx      = diff[IDXW-1:0];
    end
endmodule

// File: rtl/lcb_store.sv
// Module: lcb_store
// Tagless register array holding one captured loop; write on wr_en,
// asynchronous read. Entries carry no reset: the controller never
// selects them before a complete capture.
// Assumes: DEPTH is a power of two.
module lcb_store #(
    parameter int IW    = 32,
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [IW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [IW-1:0]   rd_data
);
    logic [IW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // Capture the fetched word into this entry when it is the one addressed.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDXW'(g))) begin
                mem[g] <= wr_data;
            end
        end
    end

    // Read port used while serving.
    always_comb rd_data = mem[rd_idx];
endmodule

// File: rtl/lcb_ctrl.sv
// Module: lcb_ctrl
// State machine: arms on a short backward branch, checks sequential fill,
// decides when the store may serve and when it must hand back to L1.
// Assumes: flags describe the instruction at the current fetch address.
module lcb_ctrl
    import lcb_pkg::*;
#(
    parameter int AW    = 16,
    parameter int OFFW  = 8,
    parameter int DEPTH = 16,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   pc,
    input  logic            sbb_taken,
    input  logic            cof_taken,
    input  logic [OFFW-1:0] sbb_off,
    input  logic [AW-1:0]   diff,
    input  logic            in_range,
    output logic [AW-1:0]   base,
    output logic [AW-1:0]   span,
    output logic            wr_en,
    output logic            use_store,
    output lcb_state_e      state
);
    lcb_state_e     nxt;
    logic [IDXW:0]  fill_pos;
    logic           off_fits;
    logic           seq_ok;
    logic           at_end;

    // Decode per-cycle conditions.
    always_comb begin
        off_fits  = (32'(sbb_off) < DEPTH);
        seq_ok    = (diff == AW'(fill_pos));
        at_end    = in_range && (diff == span);
        wr_en     = (state == ST_FILL) && seq_ok;
        use_store = (state == ST_ACTIVE) && in_range;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sbb_taken && off_fits) nxt = ST_FILL;
            end
            ST_FILL: begin
                if (!seq_ok || cof_taken) nxt = ST_ABORT;
                else if (at_end)          nxt = sbb_taken ? ST_ACTIVE : ST_IDLE;
                else if (sbb_taken)       nxt = ST_ABORT;
            end
            ST_ACTIVE: begin
                if (!in_range || cof_taken) nxt = ST_IDLE;
                else if (at_end)            nxt = sbb_taken ? ST_ACTIVE : ST_IDLE;
                else if (sbb_taken)         nxt = ST_IDLE;
            end
            ST_ABORT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State, loop bounds and fill position registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            base     <= '0;
            span     <= '0;
            fill_pos <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && sbb_taken && off_fits) begin
                base     <= pc - AW'(sbb_off);
                span     <= AW'(sbb_off);
                fill_pos <= '0;
            end else if (wr_en) begin
                fill_pos <= fill_pos + 1'b1;
            end
        end
    end

    // R2: a fitting short backward branch in idle arms capture.
    a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sbb_taken && off_fits) |=> (state == ST_FILL));
    // R2: an oversize loop leaves the block idle.
    a_r2_oversize: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && sbb_taken && !off_fits) |=> (state == ST_IDLE));
    // R4: serving only ever follows a capture pass.
    a_r4_from_fill: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_ACTIVE) |-> ($past(state) == ST_FILL));
    // R5: a control-flow change while filling aborts.
    a_r5_cof_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && cof_taken) |=> (state == ST_ABORT));
    // R5: abort lasts one cycle and ignores branches.
    a_r5_abort_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ABORT) |=> (state == ST_IDLE));
    // R9: leaving the range while active drops back to idle.
    a_r9_out_range: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !in_range) |=> (state == ST_IDLE));
endmodule

// File: rtl/loop_capture_buf.sv
// Module: loop_capture_buf
// Top: loop capture store beside L1; muxes the processor's instruction
// between L1 and the captured loop.
// Assumes: one fetch per cycle; DEPTH a power of two in 4..256.
module loop_capture_buf #(
    parameter int AW    = 16,
    parameter int IW    = 32,
    parameter int OFFW  = 8,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   fetch_pc,
    input  logic [IW-1:0]   l1_insn,
    input  logic            sbb_taken,
    input  logic            cof_taken,
    input  logic [OFFW-1:0] sbb_off,
    output logic [IW-1:0]   insn_out,
    output logic            use_store
);
    import lcb_pkg::*;
    localparam int IDXW = $clog2(DEPTH);

    logic [AW-1:0]   base;
    logic [AW-1:0]   span;
    logic [AW-1:0]   diff;
    logic [IDXW-1:0] idx;
    logic            in_range;
    logic            wr_en;
    logic [IW-1:0]   rd_data;
    lcb_state_e      state;

    lcb_xlate #(.AW(AW), .DEPTH(DEPTH)) u_xlate (
        .pc(fetch_pc), .base(base), .span(span),
        .diff(diff), .idx(idx), .in_range(in_range)
    );

    lcb_ctrl #(.AW(AW), .OFFW(OFFW), .DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .pc(fetch_pc),
        .sbb_taken(sbb_taken), .cof_taken(cof_taken), .sbb_off(sbb_off),
        .diff(diff), .in_range(in_range),
        .base(base), .span(span), .wr_en(wr_en),
        .use_store(use_store), .state(state)
    );

    lcb_store #(.IW(IW), .DEPTH(DEPTH)) u_store (
        .clk(clk), .wr_en(wr_en), .wr_idx(idx), .wr_data(l1_insn),
        .rd_idx(idx), .rd_data(rd_data)
    );

    // Output select between loop store and L1.
    always_comb insn_out = use_store ? rd_data : l1_insn;

    // R3: the store is never selected outside the serving state.
    a_r3_l1_when_filling: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ACTIVE) |-> (insn_out == l1_insn));
endmodule

// File: tb/loop_capture_buf_bench.sv
module loop_capture_buf_bench;
    localparam int AW = 16, IW = 32, OFFW = 8, DEPTH = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   fetch_pc = '0;
    logic [IW-1:0]   l1_insn = '0;
    logic            sbb_taken = 1'b0;
    logic            cof_taken = 1'b0;
    logic [OFFW-1:0] sbb_off = '0;
    logic [IW-1:0]   insn_out;
    logic            use_store;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    loop_capture_buf #(.AW(AW), .IW(IW), .OFFW(OFFW), .DEPTH(DEPTH)) u_loop_capture_buf (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .l1_insn(l1_insn),
        .sbb_taken(sbb_taken), .cof_taken(cof_taken), .sbb_off(sbb_off),
        .insn_out(insn_out), .use_store(use_store)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%0d exp<=20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [IW-1:0] word(input logic [AW-1:0] pc, input logic [15:0] salt);
        return {salt, pc};
    endfunction

    // One fetch cycle: drive at negedge, check outputs, wait for the edge.
    task automatic cyc(input logic [AW-1:0] pc, input logic sbb, input logic cof,
                       input int off, input logic [15:0] salt,
                       input logic exp_store, input logic [15:0] fill_salt,
                       input string tag);
        logic [IW-1:0] exp_insn;
        @(negedge clk);
        fetch_pc  = pc;
        sbb_taken = sbb;
        cof_taken = cof;
        sbb_off   = OFFW'(off);
        l1_insn   = word(pc, salt);
        #1;
        exp_insn = exp_store ? word(pc, fill_salt) : word(pc, salt);
        total++;
        if (use_store !== exp_store || insn_out !== exp_insn) begin
            bad++;
            $display("FAIL %s pc=%h use_store act=%0b exp=%0b insn act=%h exp=%h",
                     tag, pc, use_store, exp_store, insn_out, exp_insn);
        end
    endtask

    // One pass over a loop; close selects a taken branch at the end.
    task automatic pass(input logic [AW-1:0] start, input int len, input logic close,
                        input logic [15:0] salt, input logic exp_store,
                        input logic [15:0] fill_salt, input string tag);
        for (int i = 0; i < len; i++) begin
            cyc(start + AW'(i), close && (i == len - 1), 1'b0, len - 1,
                salt, exp_store, fill_salt, tag);
        end
    endtask

    task automatic t_reset;
        cyc(16'h0050, 1'b0, 1'b0, 0, 16'h0001, 1'b0, 16'h0, "R1 reset state");
        // Capture a loop, then reset while serving.
        pass(16'h0A00, 3, 1'b1, 16'h0011, 1'b0, 16'h0, "R1 arm");
        pass(16'h0A00, 3, 1'b1, 16'h0012, 1'b0, 16'h0, "R1 fill");
        cyc(16'h0A00, 1'b0, 1'b0, 2, 16'h0013, 1'b1, 16'h0012, "R1 serving before reset");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        pass(16'h0A00, 3, 1'b0, 16'h0014, 1'b0, 16'h0, "R1 after reset");
    endtask

    task automatic t_basic;
        pass(16'h0100, 5, 1'b1, 16'h0001, 1'b0, 16'h0, "R2 trigger");
        pass(16'h0100, 5, 1'b1, 16'h0002, 1'b0, 16'h0, "R3 fill from L1");
        pass(16'h0100, 5, 1'b1, 16'h0003, 1'b1, 16'h0002, "R4 serve");
        pass(16'h0100, 5, 1'b0, 16'h0004, 1'b1, 16'h0002, "R7 last pass served");
        cyc(16'h0105, 1'b0, 1'b0, 0, 16'h0005, 1'b0, 16'h0, "R7 exit to L1");
    endtask

    task automatic t_depth;
        pass(16'h0400, DEPTH, 1'b1, 16'h0021, 1'b0, 16'h0, "R10 trigger");
        pass(16'h0400, DEPTH, 1'b1, 16'h0022, 1'b0, 16'h0, "R10 fill");
        pass(16'h0400, DEPTH, 1'b0, 16'h0023, 1'b1, 16'h0022, "R10 full depth served");
        pass(16'h0600, DEPTH + 1, 1'b1, 16'h0031, 1'b0, 16'h0, "R2 oversize a");
        pass(16'h0600, DEPTH + 1, 1'b1, 16'h0032, 1'b0, 16'h0, "R2 oversize b");
        pass(16'h0600, DEPTH + 1, 1'b0, 16'h0033, 1'b0, 16'h0, "R2 oversize c");
    endtask

    task automatic t_cof_fill;
        pass(16'h0200, 5, 1'b1, 16'h0041, 1'b0, 16'h0, "R5 trigger");
        cyc(16'h0200, 1'b0, 1'b0, 4, 16'h0042, 1'b0, 16'h0, "R5 fill");
        cyc(16'h0201, 1'b0, 1'b0, 4, 16'h0042, 1'b0, 16'h0, "R5 fill");
        cyc(16'h0202, 1'b0, 1'b1, 4, 16'h0042, 1'b0, 16'h0, "R5 cof in fill");
        cyc(16'h0204, 1'b1, 1'b0, 4, 16'h0042, 1'b0, 16'h0, "R5 branch in abort ignored");
        pass(16'h0200, 5, 1'b1, 16'h0043, 1'b0, 16'h0, "R5 not served after abort");
        cyc(16'h0200, 1'b0, 1'b0, 4, 16'h0044, 1'b0, 16'h0, "R5 thrash fill");
        cyc(16'h0201, 1'b0, 1'b0, 4, 16'h0044, 1'b0, 16'h0, "R5 thrash fill");
        cyc(16'h0202, 1'b0, 1'b1, 4, 16'h0044, 1'b0, 16'h0, "R5 thrash cof");
        cyc(16'h0203, 1'b0, 1'b0, 4, 16'h0044, 1'b0, 16'h0, "R5 thrash abort");
        cyc(16'h0204, 1'b0, 1'b0, 4, 16'h0044, 1'b0, 16'h0, "R5 thrash idle");
    endtask

    task automatic t_gap;
        pass(16'h0300, 5, 1'b1, 16'h0051, 1'b0, 16'h0, "R6 trigger");
        cyc(16'h0300, 1'b0, 1'b0, 4, 16'h0052, 1'b0, 16'h0, "R6 fill");
        cyc(16'h0301, 1'b0, 1'b0, 4, 16'h0052, 1'b0, 16'h0, "R6 fill");
        cyc(16'h0303, 1'b0, 1'b0, 4, 16'h0052, 1'b0, 16'h0, "R6 gap");
        cyc(16'h0304, 1'b1, 1'b0, 4, 16'h0052, 1'b0, 16'h0, "R6 abort");
        pass(16'h0300, 5, 1'b1, 16'h0053, 1'b0, 16'h0, "R6 not served");
        pass(16'h0300, 5, 1'b0, 16'h0054, 1'b0, 16'h0, "R6 refill pass from L1");
    endtask

    task automatic t_active_exit;
        pass(16'h0500, 4, 1'b1, 16'h0061, 1'b0, 16'h0, "R8 trigger");
        pass(16'h0500, 4, 1'b1, 16'h0062, 1'b0, 16'h0, "R8 fill");
        cyc(16'h0500, 1'b0, 1'b0, 3, 16'h0063, 1'b1, 16'h0062, "R8 served");
        cyc(16'h0501, 1'b0, 1'b1, 3, 16'h0063, 1'b1, 16'h0062, "R8 cof word served");
        cyc(16'h0520, 1'b0, 1'b0, 3, 16'h0063, 1'b0, 16'h0, "R8 next from L1");
        cyc(16'h0502, 1'b0, 1'b0, 3, 16'h0063, 1'b0, 16'h0, "R8 idle in loop");
        pass(16'h0700, 4, 1'b1, 16'h0071, 1'b0, 16'h0, "R9 trigger");
        pass(16'h0700, 4, 1'b1, 16'h0072, 1'b0, 16'h0, "R9 fill");
        cyc(16'h0700, 1'b0, 1'b0, 3, 16'h0073, 1'b1, 16'h0072, "R9 served");
        cyc(16'h0010, 1'b0, 1'b0, 3, 16'h0073, 1'b0, 16'h0, "R9 out of range same cycle");
        cyc(16'h0701, 1'b0, 1'b0, 3, 16'h0073, 1'b0, 16'h0, "R9 idle after");
    endtask

    task automatic t_end_cof;
        pass(16'h0800, 4, 1'b1, 16'h0081, 1'b0, 16'h0, "R5 end trigger");
        for (int i = 0; i < 4; i++) begin
            cyc(16'h0800 + AW'(i), 1'b0, (i == 3), 3, 16'h0082, 1'b0, 16'h0, "R5 cof at loop end");
        end
        cyc(16'h0900, 1'b0, 1'b0, 3, 16'h0083, 1'b0, 16'h0, "R5 abort after end cof");
        pass(16'h0800, 4, 1'b1, 16'h0084, 1'b0, 16'h0, "R5 not served");
        pass(16'h0800, 4, 1'b0, 16'h0085, 1'b0, 16'h0, "R3 refill from L1");
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_depth();
        t_cof_fill();
        t_gap();
        t_active_exit();
        t_end_cof();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule